// File: doc/BRIEF.md
# Status Flags and Sense-Line Interrupt Unit

This unit owns the eight-bit processor status byte of a small accumulator machine: carry/link, overflow, two captured sense-line bits, an interrupt enable, and three general-purpose flag bits that appear on output pins. The instruction decoder raises a one-cycle strobe for each flag-control operation. The unit then sets or clears link or interrupt enable, copies the accumulator into the status byte, or captures the sense lines and returns the whole status byte as a new accumulator value.

At every instruction boundary the decoder raises `fetch_req`. If interrupts are enabled and the synchronized sense A line is high, the unit takes an interrupt. It clears the enable and swaps the program counter with pointer 3, using the same exchange datapath as the explicit pointer/PC swap instruction. The new pointer value is the old PC minus one, and the new PC is the old pointer plus one. Both steps wrap inside the low 12 bits and keep the upper four address bits. All results are registered and appear one clock after the strobe, together with write enables for the register file.

Top module: `sir_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status byte, flag pins, `ac_we`, `pc_we`, `ptr_we` and `irq_taken` are all 0 after that edge.
- R2: `op_set_link` sets status bit 7 and `op_clr_link` clears it; the other status bits keep their values.
- R3: `op_int_on` sets status bit 3 (interrupt enable) and `op_int_off` clears it; the other bits keep their values.
- R4: `op_ac_to_sr` loads all eight status bits from `ac_in`; `flag_out` shows status bits 2:0 from the next cycle on.
- R5: `op_sr_to_ac` writes synchronized sense B into bit 5 and sense A into bit 4, and one cycle later puts the resulting status byte on `ac_out` with `ac_we` high for exactly one cycle.
- R6: Sense lines pass through a two-stage synchronizer, and a change on them alone never alters status bits 5:4.
- R7: With bit 3 set and synchronized sense A high, a `fetch_req` makes `irq_taken` high in the next cycle. In that cycle bit 3 reads 0, `pc_out` = `p3_in`+1, `ptr_out` = `pc_in`-1, `ptr_sel_out` = 3, and `pc_we` and `ptr_we` are high.
- R8: No interrupt is taken when bit 3 is clear, when sense A is low, or without `fetch_req`.
- R9: `op_xch` with `xch_sel` in 1..3 gives `pc_out` = `xch_ptr_in`+1 and `ptr_out` = `pc_in`-1, with `ptr_sel_out` = `xch_sel` and `irq_taken` low.
- R10: Both exchange adjustments wrap within address bits 11:0 and leave bits 15:12 of their operand unchanged.
- R11: `irq_taken`, `pc_we` and `ptr_we` are single-cycle pulses; no interrupt can be detected in the cycle where `irq_taken` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Instruction boundary, interrupt check point |
| op_clr_link | input | 1 | Clear link strobe |
| op_set_link | input | 1 | Set link strobe |
| op_int_on | input | 1 | Enable interrupt strobe |
| op_int_off | input | 1 | Disable interrupt strobe |
| op_sr_to_ac | input | 1 | Capture sense lines and copy status to accumulator |
| op_ac_to_sr | input | 1 | Copy accumulator to status |
| op_xch | input | 1 | Explicit pointer/PC exchange strobe |
| xch_sel | input | 2 | Pointer number (1..3) for the explicit exchange |
| sense_a | input | 1 | Asynchronous sense line A, also interrupt request |
| sense_b | input | 1 | Asynchronous sense line B |
| ac_in | input | 8 | Current accumulator |
| pc_in | input | 16 | Current program counter |
| p3_in | input | 16 | Current pointer 3 |
| xch_ptr_in | input | 16 | Pointer selected by `xch_sel` |
| sr_out | output | 8 | Status byte |
| flag_out | output | 3 | User flag pins |
| ac_out | output | 8 | Accumulator write data |
| ac_we | output | 1 | Accumulator write enable |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Program counter write enable |
| ptr_out | output | 16 | New pointer value |
| ptr_we | output | 1 | Pointer write enable |
| ptr_sel_out | output | 2 | Pointer number written |
| irq_taken | output | 1 | Interrupt taken pulse |

## Verification
The checks assume the decoder asserts at most one of the operation strobes and `fetch_req` in any cycle, and that `xch_sel` is nonzero whenever `op_xch` is high. A checker property flags any breach of the first assumption. The stimulus changes one strobe at a time, each for one cycle. It holds the sense lines steady for at least three cycles before it relies on their synchronized value, so the synchronizer latency never enters an expected value.

// File: rtl/sir_pkg.sv
package sir_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = 12;
    localparam int SR_W   = 8;
    localparam int UF_W   = 3;
    localparam int SEL_W  = 2;

    // status bit positions (other blocks decode these)
    localparam int SR_CY = 7;
    localparam int SR_OV = 6;
    localparam int SR_SB = 5;
    localparam int SR_SA = 4;
    localparam int SR_IE = 3;

    localparam logic [SEL_W-1:0] IRQ_PTR = SEL_W'(3);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SR_W-1:0]   sr_t;

    typedef struct packed {
        addr_t new_pc;
        addr_t new_ptr;
    } xchg_t;

    // step an address by one inside its page, keeping the page bits
    function automatic addr_t page_step(input addr_t a, input logic dec);
        logic [PAGE_W-1:0] lo;
        lo = a[PAGE_W-1:0];
        lo = dec ? lo - 1'b1 : lo + 1'b1;
        return {a[ADDR_W-1:PAGE_W], lo};
    endfunction

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sir_xchg.sv
module sir_xchg
    import sir_pkg::*;
(
    input  addr_t pc_cur,
    input  addr_t ptr_cur,
    output xchg_t res
);
    always_comb begin
        res.new_ptr = page_step(pc_cur, 1'b1);
        res.new_pc  = page_step(ptr_cur, 1'b0);
    end
endmodule

// File: rtl/sir_status.sv
module sir_status
    import sir_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_clr_link,
    input  logic            op_set_link,
    input  logic            op_int_on,
    input  logic            op_int_off,
    input  logic            op_sr_to_ac,
    input  logic            op_ac_to_sr,
    input  logic            irq_clear,
    input  logic            sa_s,
    input  logic            sb_s,
    input  logic [SR_W-1:0] ac_in,
    output sr_t             sr,
    output logic [SR_W-1:0] ac_out,
    output logic            ac_we
);
    sr_t sr_q;
    sr_t sampled;

    always_comb begin
        sampled        = sr_q;
        sampled[SR_SB] = sb_s;
        sampled[SR_SA] = sa_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            ac_out <= '0;
            ac_we  <= 1'b0;
        end else begin
            ac_we <= op_sr_to_ac;
            if (op_sr_to_ac) ac_out <= sampled;

            if (op_ac_to_sr)      sr_q        <= ac_in;
            else if (op_sr_to_ac) sr_q        <= sampled;
            else if (op_clr_link) sr_q[SR_CY] <= 1'b0;
            else if (op_set_link) sr_q[SR_CY] <= 1'b1;
            else if (op_int_on)   sr_q[SR_IE] <= 1'b1;
            else if (op_int_off)  sr_q[SR_IE] <= 1'b0;

            if (irq_clear) sr_q[SR_IE] <= 1'b0;
        end
    end

    assign sr = sr_q;
endmodule

// File: rtl/sir_ctrl.sv
module sir_ctrl
    import sir_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic              op_clr_link,
    input  logic              op_set_link,
    input  logic              op_int_on,
    input  logic              op_int_off,
    input  logic              op_sr_to_ac,
    input  logic              op_ac_to_sr,
    input  logic              op_xch,
    input  logic [SEL_W-1:0]  xch_sel,
    input  logic              sense_a,
    input  logic              sense_b,
    input  logic [SR_W-1:0]   ac_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] p3_in,
    input  logic [ADDR_W-1:0] xch_ptr_in,
    output logic [SR_W-1:0]   sr_out,
    output logic [UF_W-1:0]   flag_out,
    output logic [SR_W-1:0]   ac_out,
    output logic              ac_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_we,
    output logic [ADDR_W-1:0] ptr_out,
    output logic              ptr_we,
    output logic [SEL_W-1:0]  ptr_sel_out,
    output logic              irq_taken
);
    logic [1:0] sense_s;
    sr_t        sr;
    logic       irq_fire;
    logic       do_xchg;
    addr_t      xchg_src;
    xchg_t      xres;

    sir_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sense_b, sense_a}),
        .q   (sense_s)
    );

    // detection is held off while the previous take is still on the outputs
    assign irq_fire = fetch_req & sr[SR_IE] & sense_s[0] & ~irq_taken;
    assign do_xchg  = irq_fire | op_xch;
    assign xchg_src = irq_fire ? p3_in : xch_ptr_in;

    sir_status u_status (
        .clk         (clk),
        .rst         (rst),
        .op_clr_link (op_clr_link),
        .op_set_link (op_set_link),
        .op_int_on   (op_int_on),
        .op_int_off  (op_int_off),
        .op_sr_to_ac (op_sr_to_ac),
        .op_ac_to_sr (op_ac_to_sr),
        .irq_clear   (irq_fire),
        .sa_s        (sense_s[0]),
        .sb_s        (sense_s[1]),
        .ac_in       (ac_in),
        .sr          (sr),
        .ac_out      (ac_out),
        .ac_we       (ac_we)
    );

    sir_xchg u_xchg (
        .pc_cur  (pc_in),
        .ptr_cur (xchg_src),
        .res     (xres)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_taken   <= 1'b0;
            pc_we       <= 1'b0;
            ptr_we      <= 1'b0;
            pc_out      <= '0;
            ptr_out     <= '0;
            ptr_sel_out <= '0;
        end else begin
            irq_taken <= irq_fire;
            pc_we     <= do_xchg;
            ptr_we    <= do_xchg;
            if (do_xchg) begin
                pc_out      <= xres.new_pc;
                ptr_out     <= xres.new_ptr;
                ptr_sel_out <= irq_fire ? IRQ_PTR : xch_sel;
            end
        end
    end

    assign sr_out   = sr;
    assign flag_out = sr[UF_W-1:0];
endmodule

// File: rtl/sir_ctrl_chk.sv
module sir_ctrl_chk
    import sir_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              op_clr_link,
    input logic              op_set_link,
    input logic              op_int_on,
    input logic              op_int_off,
    input logic              op_sr_to_ac,
    input logic              op_ac_to_sr,
    input logic              op_xch,
    input logic [SEL_W-1:0]  xch_sel,
    input logic [SR_W-1:0]   ac_in,
    input logic [ADDR_W-1:0] xch_ptr_in,
    input logic [SR_W-1:0]   sr_out,
    input logic              ac_we,
    input logic [ADDR_W-1:0] pc_out,
    input logic              pc_we,
    input logic              ptr_we,
    input logic [SEL_W-1:0]  ptr_sel_out,
    input logic              irq_taken
);
    a_in_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_req, op_clr_link, op_set_link, op_int_on, op_int_off,
                  op_sr_to_ac, op_ac_to_sr, op_xch}));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sr_out == '0 && !irq_taken && !pc_we && !ac_we));

    a_r2_link_set: assert property (@(posedge clk) disable iff (rst)
        op_set_link |=> sr_out[SR_CY]);

    a_r2_link_clr: assert property (@(posedge clk) disable iff (rst)
        op_clr_link |=> !sr_out[SR_CY]);

    a_r3_ie_on: assert property (@(posedge clk) disable iff (rst)
        op_int_on |=> sr_out[SR_IE]);

    a_r3_ie_off: assert property (@(posedge clk) disable iff (rst)
        op_int_off |=> !sr_out[SR_IE]);

    a_r4_load_all: assert property (@(posedge clk) disable iff (rst)
        op_ac_to_sr |=> sr_out == $past(ac_in));

    a_r5_ac_pulse: assert property (@(posedge clk) disable iff (rst)
        op_sr_to_ac |=> ac_we);

    a_r7_take_clears_ie: assert property (@(posedge clk) disable iff (rst)
        irq_taken |-> (!sr_out[SR_IE] && pc_we && ptr_we && ptr_sel_out == 2'd3));

    a_r8_needs_fetch: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |=> !irq_taken);

    a_r9_xch_no_irq: assert property (@(posedge clk) disable iff (rst)
        op_xch |=> (!irq_taken && ptr_sel_out == $past(xch_sel)));

    a_r10_page_kept: assert property (@(posedge clk) disable iff (rst)
        op_xch |=> pc_out[ADDR_W-1:PAGE_W] == $past(xch_ptr_in[ADDR_W-1:PAGE_W]));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_taken |=> !irq_taken);
endmodule

bind sir_ctrl sir_ctrl_chk u_chk (.*);

// File: tb/sir_ctrl_tb.sv
module sir_ctrl_tb;
    localparam time CLK_P = 5ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req, op_clr_link, op_set_link, op_int_on, op_int_off;
    logic        op_sr_to_ac, op_ac_to_sr, op_xch;
    logic [1:0]  xch_sel;
    logic        sense_a, sense_b;
    logic [7:0]  ac_in;
    logic [15:0] pc_in, p3_in, xch_ptr_in;
    logic [7:0]  sr_out, ac_out;
    logic [2:0]  flag_out;
    logic        ac_we, pc_we, ptr_we, irq_taken;
    logic [15:0] pc_out, ptr_out;
    logic [1:0]  ptr_sel_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    sir_ctrl u_dut (.*);

    // op codes: 0 none, 1 set link, 2 clr link, 3 int on, 4 int off, 5 ac->sr, 6 sr->ac
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] ac;
        logic [7:0] exp_sr;
        logic       exp_we;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 8'hA5, 8'hA5, 1'b0},   // R4
        '{3'd2, 8'h00, 8'h25, 1'b0},   // R2
        '{3'd1, 8'h00, 8'hA5, 1'b0},   // R2
        '{3'd4, 8'h00, 8'hA5, 1'b0},   // R3
        '{3'd3, 8'h00, 8'hAD, 1'b0},   // R3
        '{3'd6, 8'h00, 8'h8D, 1'b1},   // R5 senses low
        '{3'd5, 8'h7F, 8'h7F, 1'b0},   // R4
        '{3'd2, 8'h00, 8'h7F, 1'b0},   // R2
        '{3'd4, 8'h00, 8'h77, 1'b0},   // R3
        '{3'd5, 8'h5A, 8'h5A, 1'b0}    // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_req = 0; op_clr_link = 0; op_set_link = 0; op_int_on = 0;
        op_int_off = 0; op_sr_to_ac = 0; op_ac_to_sr = 0; op_xch = 0;
    endtask

    task automatic apply_op(input logic [2:0] op);
        case (op)
            3'd1: op_set_link = 1;
            3'd2: op_clr_link = 1;
            3'd3: op_int_on   = 1;
            3'd4: op_int_off  = 1;
            3'd5: op_ac_to_sr = 1;
            3'd6: op_sr_to_ac = 1;
            default: ;
        endcase
        @(negedge clk);
        idle();
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1; xch_sel = 0; sense_a = 0; sense_b = 0;
        ac_in = 0; pc_in = 0; p3_in = 0; xch_ptr_in = 0;
        wait_cyc(3);
        check("R1 sr", sr_out, 8'h00);
        check("R1 flags", flag_out, 3'd0);
        check("R1 pulses", {irq_taken, pc_we, ptr_we, ac_we}, 4'd0);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ac_in = VECS[i].ac;
            apply_op(VECS[i].op);
            check($sformatf("R2/R3/R4/R5 vec%0d sr", i), sr_out, VECS[i].exp_sr);
            check($sformatf("R4 vec%0d flags", i), flag_out, VECS[i].exp_sr[2:0]);
            check($sformatf("R5 vec%0d ac_we", i), ac_we, VECS[i].exp_we);
            if (VECS[i].exp_we) check("R5 ac_out", ac_out, VECS[i].exp_sr);
        end
        check("R5 ac_we one cycle", ac_we, 1'b0);

        // R6: sense change alone leaves bits 5:4 untouched (sr = 5A, IE set, no fetch)
        sense_a = 1; sense_b = 1;
        wait_cyc(4);
        check("R6 sense ignored", sr_out, 8'h5A);
        check("R8 no fetch no irq", irq_taken, 1'b0);
        apply_op(3'd6);
        check("R5 capture sr", sr_out, 8'h7A);
        check("R5 capture ac", ac_out, 8'h7A);

        // R8: IE clear blocks
        apply_op(3'd4);
        fetch_req = 1; pc_in = 16'h1234; p3_in = 16'h0400;
        @(negedge clk); idle();
        check("R8 ie clear", irq_taken, 1'b0);
        // R8: sense A low blocks
        sense_a = 0;
        apply_op(3'd3);
        wait_cyc(3);
        fetch_req = 1;
        @(negedge clk); idle();
        check("R8 sense low", irq_taken, 1'b0);

        // R7: take interrupt
        sense_a = 1;
        wait_cyc(3);
        fetch_req = 1;
        @(negedge clk);
        check("R7 irq", irq_taken, 1'b1);
        check("R7 ie cleared", sr_out[3], 1'b0);
        check("R7 pc", pc_out, 16'h0401);
        check("R7 ptr", ptr_out, 16'h1233);
        check("R7 sel", ptr_sel_out, 2'd3);
        check("R7 we", {pc_we, ptr_we}, 2'b11);
        @(negedge clk); idle();
        check("R11 single pulse", irq_taken, 1'b0);
        @(negedge clk);
        check("R11 we drop", {pc_we, ptr_we}, 2'b00);

        // R10: wrap through interrupt path
        apply_op(3'd3);
        pc_in = 16'h5000; p3_in = 16'h2FFF;
        fetch_req = 1;
        @(negedge clk); idle();
        check("R10 irq", irq_taken, 1'b1);
        check("R10 pc wrap", pc_out, 16'h2000);
        check("R10 ptr wrap", ptr_out, 16'h5FFF);

        // R9: explicit exchange, pointer 1
        pc_in = 16'hA800; xch_ptr_in = 16'h0010; xch_sel = 2'd1; op_xch = 1;
        @(negedge clk); idle();
        check("R9 pc", pc_out, 16'h0011);
        check("R9 ptr", ptr_out, 16'hA7FF);
        check("R9 sel", ptr_sel_out, 2'd1);
        check("R9 no irq", irq_taken, 1'b0);
        // R9/R10: pointer 2 with wrap
        pc_in = 16'h3000; xch_ptr_in = 16'h7FFF; xch_sel = 2'd2; op_xch = 1;
        @(negedge clk); idle();
        check("R10 xch pc", pc_out, 16'h7000);
        check("R10 xch ptr", ptr_out, 16'h3FFF);
        check("R9 sel2", ptr_sel_out, 2'd2);

        // R1: reset mid-run
        ac_in = 8'hFF;
        apply_op(3'd5);
        rst = 1;
        @(negedge clk);
        check("R1 reset sr", sr_out, 8'h00);
        check("R1 reset flags", flag_out, 3'd0);
        rst = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule